// File: doc/BRIEF.md
# Descriptor List Pointer Sequencer

This block tracks where a host controller's list engine stands in a singly linked chain of endpoint descriptors. It holds two pointers: a head pointer to the first descriptor and a current pointer to the descriptor the engine will serve next. It also holds two flags. One marks the list as filled, meaning software has queued new work. The other enables list processing. Descriptors are 16-byte aligned, so each pointer stores only its upper bits and the low four bits always read as zero.

Software reaches the block through a small register port. A select input picks the head pointer, the current pointer, a command/status word or a control word. Writes take effect on the clock edge, and reads are combinational. The list engine drives a pulse when it has served a descriptor, together with that descriptor's link address. It also drives a pulse when it reaches the end of the chain, and a frame boundary strobe. When the engine serves a descriptor, the current pointer takes the link address. At the end of the chain the block reloads the current pointer from the head, but only when the filled flag is set, and it then clears that flag. A frame boundary leaves the current pointer alone, so work resumes where it stopped. While processing is enabled, software cannot overwrite the current pointer.

Top module: `desc_list_seq`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge) the head pointer, current pointer, filled flag and enable flag are all 0, and `list_empty` is 1.
- R2: Selects: 0 = head pointer, 1 = current pointer, 2 = command/status, 3 = control. A pointer write stores `sw_wdata[31:4]`, and reads of that pointer return bits 3:0 as 0.
- R3: A software write to the current pointer takes effect only while the enable flag is 0. While the enable flag is 1, the write is ignored and reads return the live value.
- R4: While enabled, an `eng_served` pulse without `eng_end_of_list` loads the current pointer with `eng_next_ptr` (low four bits cleared) on the next clock edge.
- R5: While enabled, an `eng_end_of_list` pulse with the filled flag set copies the head pointer into the current pointer and clears the filled flag on the next edge.
- R6: While enabled, an `eng_end_of_list` pulse with the filled flag clear leaves the current pointer unchanged.
- R7: A `frame_tick` pulse by itself leaves the current pointer unchanged.
- R8: The filled flag is bit 1 of command/status. Writing 1 to that bit sets the flag, and writing 0 has no effect. The enable flag is bit 4 of control and can be read and written. All other bits of both words read as 0.
- R9: A software set of the filled flag in the same cycle as an end-of-list pulse wins, so the flag is 1 afterwards. Whether the reload happens still depends on the flag value before that edge.
- R10: `list_empty` is 1 exactly when the current pointer is 0.
- R11: While the enable flag is 0, the engine pulses change neither the current pointer nor the filled flag.
- R12: When `eng_served` and `eng_end_of_list` arrive in the same cycle, end-of-list handling applies and the served address is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_sel | input | 2 | Register select (0 head, 1 current, 2 command/status, 3 control) |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Read data for the selected register |
| eng_served | input | 1 | Engine finished a descriptor |
| eng_next_ptr | input | 32 | Link address of the next descriptor |
| eng_end_of_list | input | 1 | Engine reached the end of the chain |
| frame_tick | input | 1 | Frame boundary strobe |
| cur_ptr | output | 32 | Current descriptor pointer |
| list_enable | output | 1 | List processing enabled |
| list_empty | output | 1 | Current pointer is 0 |

## Verification
The assertions assume that the engine pulses and the software strobe are single-cycle and stable around the clock edge. They also assume that a software current-pointer write never coincides with an engine update. The block makes the second assumption safe by gating one against the other on the enable flag. The stimulus drives every input at the falling edge and clears it one cycle later. It combines a software strobe with an engine pulse only where a requirement describes that collision: a filled-flag set with end-of-list, and a current-pointer write while enabled.

// File: rtl/desc_list_seq.sv
module desc_list_seq #(
  parameter int PTR_W      = 32,
  parameter int ALIGN_BITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr_en,
  input  logic [1:0]       sw_sel,
  input  logic [PTR_W-1:0] sw_wdata,
  output logic [PTR_W-1:0] sw_rdata,
  input  logic             eng_served,
  input  logic [PTR_W-1:0] eng_next_ptr,
  input  logic             eng_end_of_list,
  input  logic             frame_tick,
  output logic [PTR_W-1:0] cur_ptr,
  output logic             list_enable,
  output logic             list_empty
);
  localparam int ADDR_W   = PTR_W - ALIGN_BITS;
  localparam int FILL_BIT = 1;
  localparam int EN_BIT   = 4;

  logic [ADDR_W-1:0] head_q, cur_q, cur_nxt;
  logic              filled_q, fill_nxt, en_q;

  wire wr_head = sw_wr_en && (sw_sel == 2'd0);
  wire wr_cur  = sw_wr_en && (sw_sel == 2'd1);
  wire wr_cmd  = sw_wr_en && (sw_sel == 2'd2);
  wire wr_ctl  = sw_wr_en && (sw_sel == 2'd3);

  wire unused_ok = ^{sw_wdata[ALIGN_BITS-1:0], eng_next_ptr[ALIGN_BITS-1:0], frame_tick};

  always_comb begin
    cur_nxt  = cur_q;
    fill_nxt = filled_q;
    if (en_q) begin
      if (eng_end_of_list) begin
        if (filled_q) begin
          cur_nxt  = head_q;
          fill_nxt = 1'b0;
        end
      end else if (eng_served) begin
        cur_nxt = eng_next_ptr[PTR_W-1:ALIGN_BITS];
      end
    end else if (wr_cur) begin
      cur_nxt = sw_wdata[PTR_W-1:ALIGN_BITS];
    end
    if (wr_cmd && sw_wdata[FILL_BIT]) fill_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q   <= '0;
      cur_q    <= '0;
      filled_q <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      if (wr_head) head_q <= sw_wdata[PTR_W-1:ALIGN_BITS];
      if (wr_ctl)  en_q   <= sw_wdata[EN_BIT];
      cur_q    <= cur_nxt;
      filled_q <= fill_nxt;
    end
  end

  always_comb begin
    sw_rdata = '0;
    case (sw_sel)
      2'd0: sw_rdata = {head_q, {ALIGN_BITS{1'b0}}};
      2'd1: sw_rdata = {cur_q, {ALIGN_BITS{1'b0}}};
      2'd2: sw_rdata[FILL_BIT] = filled_q;
      default: sw_rdata[EN_BIT] = en_q;
    endcase
  end

  assign cur_ptr     = {cur_q, {ALIGN_BITS{1'b0}}};
  assign list_enable = en_q;
  assign list_empty  = (cur_q == '0);

  // R3
  cur_wr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && wr_cur && !eng_served && !eng_end_of_list) |=> (cur_ptr == $past(cur_ptr)));

  // R4
  served_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && eng_served && !eng_end_of_list) |=>
      (cur_ptr[PTR_W-1:ALIGN_BITS] == $past(eng_next_ptr[PTR_W-1:ALIGN_BITS])));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && eng_end_of_list && filled_q && !wr_cmd) |=> (cur_q == $past(head_q) && !filled_q));

  // R6
  no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && eng_end_of_list && !filled_q) |=> $stable(cur_ptr));

  // R7
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !eng_served && !eng_end_of_list && !wr_cur) |=> $stable(cur_ptr));

  // R9
  fill_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && sw_wdata[FILL_BIT]) |=> filled_q);

  // R11
  idle_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_cur) |=> $stable(cur_ptr));
endmodule

// File: tb/desc_list_seq_tb.sv
`timescale 1ns/1ps
module desc_list_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr_en = 1'b0;
  logic [1:0]  sw_sel = 2'd0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;
  logic        eng_served = 1'b0;
  logic [31:0] eng_next_ptr = '0;
  logic        eng_end_of_list = 1'b0;
  logic        frame_tick = 1'b0;
  logic [31:0] cur_ptr;
  logic        list_enable, list_empty;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  desc_list_seq dut_i (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_sel(sw_sel),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .eng_served(eng_served),
    .eng_next_ptr(eng_next_ptr), .eng_end_of_list(eng_end_of_list),
    .frame_tick(frame_tick), .cur_ptr(cur_ptr), .list_enable(list_enable),
    .list_empty(list_empty));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [1:0] sel, input logic [31:0] d,
                      input logic srv, input logic [31:0] nxt, input logic eol, input logic tick);
    @(negedge clk);
    sw_wr_en = wr; sw_sel = sel; sw_wdata = d;
    eng_served = srv; eng_next_ptr = nxt; eng_end_of_list = eol; frame_tick = tick;
    @(negedge clk);
    sw_wr_en = 1'b0; eng_served = 1'b0; eng_end_of_list = 1'b0; frame_tick = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    step(1'b1, sel, d, 1'b0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic rd_chk(input string req, input logic [1:0] sel, input logic [31:0] exp);
    sw_sel = sel;
    #1;
    chk(req, sw_rdata, exp);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_chk("R1 head", 2'd0, 32'h0);
    rd_chk("R1 cur", 2'd1, 32'h0);
    rd_chk("R1 cmd", 2'd2, 32'h0);
    rd_chk("R1 ctl", 2'd3, 32'h0);
    chk("R1 R10 empty", {31'h0, list_empty}, 32'h1);
  endtask

  task automatic t_regs;
    wr(2'd0, 32'h1234_567F);
    rd_chk("R2 head", 2'd0, 32'h1234_5670);
    wr(2'd1, 32'hABCD_EF0F);
    rd_chk("R2 R3 cur", 2'd1, 32'hABCD_EF00);
    chk("R10 not empty", {31'h0, list_empty}, 32'h0);
    wr(2'd2, 32'hFFFF_FFFD);
    rd_chk("R8 fill write0", 2'd2, 32'h0);
    wr(2'd2, 32'h0000_0002);
    rd_chk("R8 fill set", 2'd2, 32'h2);
    wr(2'd3, 32'hFFFF_FFFF);
    rd_chk("R8 ctl", 2'd3, 32'h10);
    chk("R8 enable out", {31'h0, list_enable}, 32'h1);
  endtask

  task automatic t_lock;
    wr(2'd1, 32'h0000_5550);
    rd_chk("R3 locked", 2'd1, 32'hABCD_EF00);
  endtask

  task automatic t_served;
    step(1'b0, 2'd0, 32'h0, 1'b1, 32'h0000_2008, 1'b0, 1'b0);
    chk("R4 served", cur_ptr, 32'h0000_2000);
    step(1'b0, 2'd0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1);
    chk("R7 frame", cur_ptr, 32'h0000_2000);
  endtask

  task automatic t_eol_filled;
    step(1'b0, 2'd0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0);
    chk("R5 reload", cur_ptr, 32'h1234_5670);
    rd_chk("R5 fill cleared", 2'd2, 32'h0);
  endtask

  task automatic t_eol_empty;
    step(1'b0, 2'd0, 32'h0, 1'b1, 32'h0000_0000, 1'b0, 1'b0);
    chk("R10 empty", {31'h0, list_empty}, 32'h1);
    step(1'b0, 2'd0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0);
    chk("R6 no reload", cur_ptr, 32'h0);
  endtask

  task automatic t_prio;
    step(1'b1, 2'd2, 32'h2, 1'b0, 32'h0, 1'b1, 1'b0);
    chk("R9 cur kept", cur_ptr, 32'h0);
    rd_chk("R9 flag set", 2'd2, 32'h2);
    step(1'b1, 2'd2, 32'h2, 1'b0, 32'h0, 1'b1, 1'b0);
    chk("R9 reload", cur_ptr, 32'h1234_5670);
    rd_chk("R9 flag kept", 2'd2, 32'h2);
  endtask

  task automatic t_both;
    step(1'b0, 2'd0, 32'h0, 1'b1, 32'h0000_9990, 1'b1, 1'b0);
    chk("R12 eol wins", cur_ptr, 32'h1234_5670);
    step(1'b0, 2'd0, 32'h0, 1'b1, 32'h0000_3000, 1'b0, 1'b0);
    step(1'b0, 2'd0, 32'h0, 1'b1, 32'h0000_4440, 1'b1, 1'b0);
    chk("R12 served dropped", cur_ptr, 32'h0000_3000);
  endtask

  task automatic t_disabled;
    wr(2'd3, 32'h0);
    wr(2'd2, 32'h2);
    step(1'b0, 2'd0, 32'h0, 1'b1, 32'h0000_5550, 1'b0, 1'b0);
    chk("R11 served ignored", cur_ptr, 32'h0000_3000);
    step(1'b0, 2'd0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0);
    chk("R11 eol ignored", cur_ptr, 32'h0000_3000);
    rd_chk("R11 flag kept", 2'd2, 32'h2);
    wr(2'd1, 32'h0000_7770);
    chk("R3 write open", cur_ptr, 32'h0000_7770);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_lock();
    t_served();
    t_eol_filled();
    t_eol_empty();
    t_prio();
    t_both();
    t_disabled();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule